// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block turns plain bus accesses on a memory window into serial flash transactions. A bus read starts a complete sequence on the SPI pins: it lowers the selected chip select, sends the opcode and the address, adds any dummy bytes, shifts in four data bytes and returns them as one 32-bit word. Each chip select has its own 32-bit control word. That word sets the access mode, the fast-read opcode, the dummy byte count, the clock divisor and the data lane width. A separate register chooses 3-byte or 4-byte addressing for each chip select.

Two further modes change what a bus write does. In program mode, a bus write sends a page-program command with one data byte. In user mode, the engine stops framing transactions. Software then drives the flash one byte at a time, and a control bit holds the chip select line at the level software chooses.

Top module: `spi_flash_reader`

## Requirements
- R1: After reset every chip select is high, SCK is low, `mem_ready` is low and every register reads as zero.
- R2: The control word for chip select i is at register offset 0x10+4*i, and the address-width register is at offset 0x04 with bit i for chip select i. Any other offset reads as zero. Control word fields: [1:0] mode (0 read, 1 fast read, 2 program, 3 user), [2] user chip-select level, [7:6] dummy byte count, [11:8] divisor code, [23:16] fast-read opcode, [31:28] lane code.
- R3: SCK idles low and changes only during a transaction. It stays in each phase for D system cycles, where D is the divisor code, or 16 when the code is 0. Output data changes after falling edges and input is sampled on rising edges (SPI mode 0).
- R4: A bus read in mode 0 or mode 2 sends opcode 0x03, then the address, then four data clocks-bytes, with no dummy bytes, all on one lane. Each byte is sent most significant bit first on `spi_do`.
- R5: When the address-width bit for the selected chip select is set, four address bytes are sent, most significant byte first. When it is clear, the low three bytes are sent.
- R6: A bus read in mode 1 sends the opcode from the control word, the address, and then as many dummy bytes as the dummy count. Each dummy byte lasts 8 clocks and drives 0.
- R7: In mode 1 with lane code 2 or 3, each data byte takes 4 clocks and `spi_do_en` is low. `spi_di[1]` carries the higher bit of each pair. Any other lane code uses one lane and samples `spi_di[1]`.
- R8: Data byte j read from address A+j lands in `mem_rdata[8j+7:8j]`. The chip select rises and `mem_ready` pulses for one cycle exactly 2*D*N cycles after the request is accepted, where N is the number of SCK clocks.
- R9: A bus write in mode 2 sends opcode 0x02, then the address, then `mem_wdata[7:0]`.
- R10: A bus write in mode 0 or 1 is ignored. `mem_ready` pulses in the cycle after acceptance, and no chip select or SCK activity occurs.
- R11: In user mode the chip select pin follows control bit 2, where 1 means high. A bus write shifts out `mem_wdata[7:0]` over 8 clocks. A bus read shifts in one byte from `spi_di[1]` and returns it in `mem_rdata[7:0]`, with the upper bits zero.
- R12: During a framed transaction only the chosen chip select is driven low by the engine. The other chip selects keep their idle or user-mode level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | input | 1 | Window access request, held until ready |
| mem_we | input | 1 | Window access is a write |
| mem_sel | input | SELW | Chip select chosen for the access |
| mem_addr | input | AW | Flash byte address |
| mem_wdata | input | 8 | Byte for program or user writes |
| mem_rdata | output | 32 | Assembled read word |
| mem_ready | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | NCS | Active-low chip selects |
| spi_do | output | 1 | Serial data out (lane 0) |
| spi_do_en | output | 1 | Output enable for lane 0 |
| spi_di | input | 2 | Serial data in, [1] primary lane, [0] second lane in dual mode |

## Verification
The assertions assume a master that holds `mem_req`, `mem_we`, `mem_sel`, `mem_addr` and `mem_wdata` steady until `mem_ready`, drops the request in the following cycle, and only selects chip selects that exist. They also assume that no register write arrives while a transaction is running. The bench keeps within these assumptions by issuing one request at a time from a task, and it waits for the ready pulse before it writes any register. It also drives `spi_di` only just after falling SCK edges, which keeps the sampled value stable around each rising edge.

// File: rtl/spi_flash_reader.sv
`timescale 1ns/1ps
module spi_flash_reader #(
  parameter int NCS = 3,
  parameter int AW = 32,
  parameter int RAW = 8,
  localparam int SELW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            mem_req,
  input  logic            mem_we,
  input  logic [SELW-1:0] mem_sel,
  input  logic [AW-1:0]   mem_addr,
  input  logic [7:0]      mem_wdata,
  output logic [31:0]     mem_rdata,
  output logic            mem_ready,
  output logic            spi_sck,
  output logic [NCS-1:0]  spi_cs_n,
  output logic            spi_do,
  output logic            spi_do_en,
  input  logic [1:0]      spi_di
);
  localparam int CTRL_BASE = 16;
  localparam int WIDE_OFS  = 4;

  logic [31:0]    ctrl_q [NCS];
  logic [NCS-1:0] wide_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wide_q <= '0;
      for (int i = 0; i < NCS; i++) ctrl_q[i] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == RAW'(WIDE_OFS)) wide_q <= reg_wdata[NCS-1:0];
      for (int i = 0; i < NCS; i++)
        if (reg_addr == RAW'(CTRL_BASE + 4*i)) ctrl_q[i] <= reg_wdata;
    end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(WIDE_OFS)) reg_rdata[NCS-1:0] = wide_q;
    for (int i = 0; i < NCS; i++)
      if (reg_addr == RAW'(CTRL_BASE + 4*i)) reg_rdata = ctrl_q[i];
  end

  // fields of the control word for the requested chip select
  logic [1:0] s_mode, s_ndum;
  logic [7:0] s_opreg;
  logic [3:0] s_code, s_io;
  logic       s_wide;
  always_comb begin
    s_mode = '0; s_ndum = '0; s_opreg = '0; s_code = '0; s_io = '0; s_wide = 1'b0;
    for (int i = 0; i < NCS; i++)
      if (mem_sel == SELW'(i)) begin
        s_mode  = ctrl_q[i][1:0];
        s_ndum  = ctrl_q[i][7:6];
        s_code  = ctrl_q[i][11:8];
        s_opreg = ctrl_q[i][23:16];
        s_io    = ctrl_q[i][31:28];
        s_wide  = wide_q[i];
      end
  end

  wire       s_user   = s_mode == 2'd3;
  wire       s_fast   = s_mode == 2'd1 && !mem_we;
  wire       s_ignore = mem_we && !s_mode[1];
  wire [7:0] s_op     = s_fast ? s_opreg : (mem_we ? 8'h02 : 8'h03);
  wire [2:0] s_alen   = s_wide ? 3'd4 : 3'd3;
  wire [1:0] s_dcnt   = s_fast ? s_ndum : 2'd0;
  wire [3:0] s_ndata  = mem_we ? 4'd1 : 4'd4;
  wire [3:0] s_hdr    = s_user ? 4'd0 : 4'd1 + {1'b0, s_alen} + {2'b0, s_dcnt};
  wire [3:0] s_tot    = s_user ? 4'd1 : s_hdr + s_ndata;
  wire [4:0] s_div    = (s_code == 4'd0) ? 5'd16 : {1'b0, s_code};
  wire       s_dual   = s_fast && (s_io == 4'd2 || s_io == 4'd3);
  wire [7:0] s_first  = s_user ? (mem_we ? mem_wdata : 8'h00) : s_op;

  logic            busy, sck_q, ready_q;
  logic [SELW-1:0] cur;
  logic            t_user, t_we, t_dual;
  logic [31:0]     t_addr;
  logic [2:0]      t_alen;
  logic [1:0]      t_dcnt;
  logic [3:0]      t_hdr, t_tot, bidx;
  logic [4:0]      t_div, div_q;
  logic [7:0]      t_wbyte, sh, rxb, nb;
  logic [2:0]      bc;
  logic [31:0]     rword;

  wire       tick     = busy && div_q == t_div - 5'd1;
  wire       in_data  = bidx >= t_hdr && !t_we;
  wire       dual_now = t_dual && in_data;
  wire       cpb_last = dual_now ? bc[1:0] == 2'd3 : bc == 3'd7;
  wire [1:0] doff     = 2'(bidx - t_hdr);
  wire [3:0] apos     = {1'b0, t_alen} - 4'd1 - bidx;

  // byte sent after the current one; bidx also counts address bytes already started
  always_comb begin
    if (bidx < {1'b0, t_alen})
      nb = 8'(t_addr >> {apos[1:0], 3'b000});
    else if (bidx < {1'b0, t_alen} + {2'b0, t_dcnt})
      nb = 8'h00;
    else if (t_we)
      nb = t_wbyte;
    else
      nb = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; sck_q <= 1'b0; ready_q <= 1'b0; cur <= '0;
      t_user <= 1'b0; t_we <= 1'b0; t_dual <= 1'b0; t_addr <= '0;
      t_alen <= '0; t_dcnt <= '0; t_hdr <= '0; t_tot <= '0; t_div <= 5'd1;
      t_wbyte <= '0; div_q <= '0; bidx <= '0; bc <= '0;
      sh <= '0; rxb <= '0; rword <= '0;
    end else begin
      ready_q <= 1'b0;
      if (!busy) begin
        if (mem_req && !ready_q) begin
          if (s_ignore) ready_q <= 1'b1;
          else begin
            busy <= 1'b1; cur <= mem_sel;
            t_user <= s_user; t_we <= mem_we; t_dual <= s_dual;
            t_addr <= 32'(mem_addr); t_alen <= s_alen; t_dcnt <= s_dcnt;
            t_hdr <= s_hdr; t_tot <= s_tot; t_div <= s_div; t_wbyte <= mem_wdata;
            sh <= s_first; div_q <= '0; sck_q <= 1'b0;
            bidx <= '0; bc <= '0; rxb <= '0; rword <= '0;
          end
        end
      end else begin
        div_q <= tick ? 5'd0 : div_q + 5'd1;
        if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rxb <= dual_now ? {rxb[5:0], spi_di} : {rxb[6:0], spi_di[1]};
          end else begin
            sck_q <= 1'b0;
            bc <= bc + 3'd1;
            sh <= {sh[6:0], 1'b0};
            if (cpb_last) begin
              bc <= '0;
              if (in_data) rword[{doff, 3'b000} +: 8] <= rxb;
              if (bidx == t_tot - 4'd1) begin
                busy <= 1'b0;
                ready_q <= 1'b1;
              end else begin
                bidx <= bidx + 4'd1;
                sh <= nb;
              end
            end
          end
        end
      end
    end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign spi_cs_n[g] = (busy && !t_user && cur == SELW'(g)) ? 1'b0
                       : ((ctrl_q[g][1:0] == 2'd3) ? ctrl_q[g][2] : 1'b1);
  end

  assign spi_sck   = sck_q;
  assign spi_do    = busy & sh[7];
  assign spi_do_en = busy & !dual_now;
  assign mem_rdata = rword;
  assign mem_ready = ready_q;

  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> !mem_ready);
  // R8
  end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> mem_ready);
  // R10
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !busy && !mem_ready && s_ignore) |=> (mem_ready && !busy && !spi_sck));
  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);
endmodule

// File: tb/spi_flash_reader_bench.sv
`timescale 1ns/1ps
module spi_flash_reader_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_rdata;
  logic mem_req = 1'b0, mem_we = 1'b0, mem_ready;
  logic [1:0] mem_sel = '0;
  logic [31:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic spi_sck, spi_do, spi_do_en;
  logic [2:0] spi_cs_n;
  logic [1:0] spi_di = '0;

  int tests = 0, fails = 0;
  logic [31:0] sh_ctrl [3];
  logic [2:0]  sh_wide;
  logic        exp_out [0:127];
  logic        exp_oe  [0:127];
  logic [1:0]  drv     [0:127];
  int          nclk;

  always #2.5 clk = ~clk;

  spi_flash_reader u_spi_flash_reader (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_do(spi_do),
    .spi_do_en(spi_do_en), .spi_di(spi_di));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5C;
  endfunction

  function automatic logic [2:0] cs_exp(input bit active, input int sel, input bit user);
    logic [2:0] v;
    for (int i = 0; i < 3; i++)
      v[i] = (active && !user && i == sel) ? 1'b0
           : ((sh_ctrl[i][1:0] == 2'd3) ? sh_ctrl[i][2] : 1'b1);
    return v;
  endfunction

  task automatic add_out(input logic [7:0] b);
    for (int j = 0; j < 8; j++) begin
      exp_out[nclk] = b[7-j]; exp_oe[nclk] = 1'b1; drv[nclk] = 2'b00; nclk++;
    end
  endtask

  task automatic add_in(input logic [7:0] b, input bit dual);
    if (dual)
      for (int j = 0; j < 4; j++) begin
        exp_out[nclk] = 1'b0; exp_oe[nclk] = 1'b0; drv[nclk] = {b[7-2*j], b[6-2*j]}; nclk++;
      end
    else
      for (int j = 0; j < 8; j++) begin
        exp_out[nclk] = 1'b0; exp_oe[nclk] = 1'b1; drv[nclk] = {b[7-j], 1'b0}; nclk++;
      end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    if (a == 8'h04) sh_wide = d[2:0];
    for (int i = 0; i < 3; i++) if (a == 8'(16 + 4*i)) sh_ctrl[i] = d;
  endtask

  task automatic rreg(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata === exp, req, "register read", reg_rdata, exp);
  endtask

  task automatic run(input int sel, input bit we, input logic [31:0] addr,
                     input logic [7:0] wb, input logic [7:0] ub, input string req);
    logic [31:0] c, exp_rd;
    logic [7:0] act_v, exp_v;
    int mode, dd, alen, ndum, total, errs, bad_k, cc;
    bit user, ign, fast, dual, exp_sck;
    c = sh_ctrl[sel]; mode = int'(c[1:0]);
    user = mode == 3; ign = we && mode < 2; fast = mode == 1 && !we;
    dd = (c[11:8] == 4'd0) ? 16 : int'(c[11:8]);
    dual = fast && (c[31:28] == 4'd2 || c[31:28] == 4'd3);
    alen = sh_wide[sel] ? 4 : 3; ndum = fast ? int'(c[7:6]) : 0;
    exp_rd = '0; nclk = 0; errs = 0; bad_k = 0; act_v = '0; exp_v = '0;
    if (user) begin
      if (we) add_out(wb);
      else begin add_in(ub, 1'b0); exp_rd = {24'h0, ub}; end
    end else if (!ign) begin
      add_out(fast ? c[23:16] : (we ? 8'h02 : 8'h03));
      for (int a = 0; a < alen; a++) add_out(8'(addr >> (8 * (alen - 1 - a))));
      for (int d = 0; d < ndum; d++) add_out(8'h00);
      if (we) add_out(wb);
      else
        for (int j = 0; j < 4; j++) begin
          add_in(mem_byte(addr + 32'(j)), dual);
          exp_rd[8*j +: 8] = mem_byte(addr + 32'(j));
        end
    end
    total = ign ? 0 : 2 * nclk * dd;
    @(negedge clk);
    mem_req = 1'b1; mem_we = we; mem_sel = 2'(sel); mem_addr = addr; mem_wdata = wb; spi_di = 2'b00;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < total; k++) begin
      cc = k / (2 * dd);
      exp_sck = ((k / dd) % 2) == 1;
      exp_v = {1'b0, exp_sck, exp_oe[cc], exp_oe[cc] ? exp_out[cc] : spi_do, 1'b0, cs_exp(1'b1, sel, user)};
      act_v = {mem_ready, spi_sck, spi_do_en, spi_do, 1'b0, spi_cs_n};
      if (act_v !== exp_v && errs == 0) begin
        errs = 1; bad_k = k;
        $display("FAIL %s pins at cycle %0d actual=%h expected=%h", req, k, act_v, exp_v);
      end
      spi_di = drv[cc];
      @(negedge clk);
    end
    tests++;
    if (errs != 0) fails++;
    check(mem_ready === 1'b1 && spi_sck === 1'b0 && spi_cs_n === cs_exp(1'b0, sel, user),
          req, "completion cycle", {mem_ready, spi_sck, 1'b0, spi_cs_n},
          {1'b1, 1'b0, 1'b0, cs_exp(1'b0, sel, user)});
    if (!we) check(mem_rdata === exp_rd, req, "read word", mem_rdata, exp_rd);
    mem_req = 1'b0;
    if (bad_k < 0) $display("unreachable");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) sh_ctrl[i] = '0;
    sh_wide = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(spi_cs_n === 3'b111 && spi_sck === 1'b0 && mem_ready === 1'b0, "R1",
          "idle pins", {mem_ready, spi_sck, spi_cs_n}, 32'h7);
    rreg(8'h10, 32'h0, "R1");
    rreg(8'h04, 32'h0, "R1");
    // R2
    wreg(8'h10, 32'h0000_0200);
    rreg(8'h10, 32'h0000_0200, "R2");
    wreg(8'h04, 32'h0000_0002);
    rreg(8'h04, 32'h0000_0002, "R2");
    rreg(8'h08, 32'h0, "R2");
    // R4 plain read, R8 word assembly and timing
    run(0, 1'b0, 32'h0001_2345, 8'h00, 8'h00, "R4");
    run(0, 1'b0, 32'h0000_0200, 8'h00, 8'h00, "R8");
    // R3 divisor code 0 means 16 cycles per phase
    wreg(8'h10, 32'h0000_0000);
    run(0, 1'b0, 32'h0000_ABCD, 8'h00, 8'h00, "R3");
    // R5 four address bytes on select 1, divisor 1
    wreg(8'h14, 32'h0000_0100);
    run(1, 1'b0, 32'h89AB_CDEF, 8'h00, 8'h00, "R5");
    // R6 fast read with one dummy byte
    wreg(8'h10, 32'h000B_0341);
    run(0, 1'b0, 32'h0000_0400, 8'h00, 8'h00, "R6");
    // R7 dual data lanes, three dummy bytes
    wreg(8'h10, 32'h206B_02C1);
    run(0, 1'b0, 32'h0003_1000, 8'h00, 8'h00, "R7");
    wreg(8'h10, 32'h30BB_0101);
    run(0, 1'b0, 32'h0000_7777, 8'h00, 8'h00, "R7");
    // R7 other lane code stays single
    wreg(8'h10, 32'h400B_0141);
    run(0, 1'b0, 32'h0000_0055, 8'h00, 8'h00, "R7");
    // R9 program write, and read in program mode
    wreg(8'h18, 32'h0000_0202);
    run(2, 1'b1, 32'h0000_1000, 8'hA7, 8'h00, "R9");
    run(2, 1'b0, 32'h0000_1004, 8'h00, 8'h00, "R4");
    // R10 writes ignored in read modes
    wreg(8'h10, 32'h0000_0200);
    run(0, 1'b1, 32'h0000_0010, 8'h11, 8'h00, "R10");
    wreg(8'h10, 32'h000B_0201);
    run(0, 1'b1, 32'h0000_0020, 8'h22, 8'h00, "R10");
    // R11 user mode chip select level and byte shifting
    wreg(8'h18, 32'h0000_0207);
    check(spi_cs_n === 3'b111, "R11", "user cs high", {29'h0, spi_cs_n}, 32'h7);
    wreg(8'h18, 32'h0000_0203);
    check(spi_cs_n === 3'b011, "R11", "user cs low", {29'h0, spi_cs_n}, 32'h3);
    run(2, 1'b1, 32'h0, 8'h3C, 8'h00, "R11");
    run(2, 1'b0, 32'h0, 8'h00, 8'hC5, "R11");
    // R12 framed read on select 0 leaves select 2 at its user level
    wreg(8'h10, 32'h0000_0200);
    run(0, 1'b0, 32'h0000_0900, 8'h00, 8'h00, "R12");
    wreg(8'h18, 32'h0000_0207);
    check(spi_cs_n === 3'b111, "R12", "all released", {29'h0, spi_cs_n}, 32'h7);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule